// File: doc/BRIEF.md
# Word-Load Mailbox with Running CRC-16

This block lets a management host fill an on-chip memory with 32-bit words through a narrow 16-bit register port, such as the one behind a clause-45 management register decoder. The host programs a starting byte address in two halves, places the upper and lower halves of a data word in two staging registers, and then commits the word with a single control write. The committed word goes out on a 32-bit memory write port with a valid/ready handshake.

After every commit the internal word address moves forward by four bytes, so a contiguous block needs only one address setup. A bit-serial CRC-16 (polynomial 0x1021, seed zero, no reflection, no final inversion) is folded over each committed word, most significant byte first. The host reads the result back and compares it with its own CRC of the data it sent, which confirms the transfer. A busy flag guards the single staging slot. A commit issued while busy is dropped and recorded in a sticky overflow flag that clears when the host reads it.

Register offsets relative to `BASE` (default 0x0200): +0 control/status, +1 CRC readback, +2 address high half, +3 address low half, +4 data high half, +5 data low half.

Top module: `wordload_mailbox`

## Requirements
- R1: After reset every readable register returns 0x0000, the busy flag is low and `mem_valid` is low.
- R2: Bits 1:0 of the address low half are discarded on write and read back as zero, so every memory address driven is word aligned.
- R3: A control write with bit 15 (execute) and bit 14 (write) both set, issued while not busy, drives `mem_valid` high on the next cycle with `mem_data` = {data high, data low} and `mem_addr` = the current word address.
- R4: A control write carrying only one of bit 15 and bit 14 starts no memory write and changes neither the address nor the CRC.
- R5: Each commit advances the word address by 4. A write to either address half reloads the address from the full programmed pair.
- R6: Register +1 returns the CRC-16 (poly 0x1021, init 0, MSB-first, no final XOR) over the four big-endian bytes of every committed word since the last clear, valid once busy has dropped.
- R7: A control write with bit 12 set while not busy clears the CRC to 0x0000. When it carries a commit in the same write, the new word is folded into the cleared value.
- R8: Control bit 8 (busy) is high from the cycle after a commit until the memory port has accepted the word and 32 CRC cycles have elapsed, whichever is later.
- R9: A commit issued while busy is dropped and sets control bit 0 (overflow). Any control write made while busy leaves the CRC untouched. A read of the control register clears overflow, but a new set in the same cycle takes priority.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears overflow on control read) |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_data | output | 32 | Memory write data |

## Verification
Register writes take effect at the clock edge that samples the strobe, and read data is combinational. Staging and address readback can therefore be compared in the cycle after a write. `mem_valid`, `mem_addr` and `mem_data` appear one edge after the commit and fall one edge after the handshake. Busy falls 32 edges after the commit at the earliest, and the CRC readback is compared only once busy is low. The bench model advances at each rising edge from the same sampled inputs, and it is compared on the following falling edge against exactly these latencies.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Control register bit positions
  localparam int CTL_EXEC   = 15;
  localparam int CTL_WRITE  = 14;
  localparam int CTL_CRCCLR = 12;
  localparam int CTL_BUSY   = 8;
  localparam int CTL_OVF    = 0;

  // Register selects, value = offset from the base address
  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_CRC  = 3'd1,
    SEL_AHI  = 3'd2,
    SEL_ALO  = 3'd3,
    SEL_DHI  = 3'd4,
    SEL_DLO  = 3'd5,
    SEL_NONE = 3'd7
  } reg_sel_e;

  localparam int NUM_REGS = 6;

endpackage

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
#(
  parameter int              REG_W = 16,
  parameter int              RA_W  = 16,
  parameter logic [RA_W-1:0] BASE  = 16'h0200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [RA_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               busy,
  input  logic [REG_W-1:0]   crc_val,
  output logic               commit,
  output logic               crc_clr,
  output logic [2*REG_W-1:0] word_addr,
  output logic [2*REG_W-1:0] data_word,
  output logic               ovf_flag
);

  localparam int AW = 2 * REG_W;
  localparam logic [REG_W-1:0] ALIGN_MASK = ~REG_W'(3);

  reg_sel_e         sel;
  logic [RA_W-1:0]  off;
  logic             wr_ctrl, wr_ahi, wr_alo, wr_dhi, wr_dlo;
  logic             both_bits, ovf_set, ovf_clr;

  logic [REG_W-1:0] ahi_q, alo_q, dhi_q, dlo_q;
  logic [REG_W-1:0] alo_nxt;
  logic [AW-1:0]    cnt_q, cnt_nxt;
  logic             cnt_en;
  logic             ovf_q, ovf_nxt, ovf_en;

  // Address decode
  assign off = reg_addr - BASE;

  always_comb begin
    sel = SEL_NONE;
    if (reg_addr >= BASE && off < RA_W'(NUM_REGS))
      sel = reg_sel_e'(off[2:0]);
  end

  assign wr_ctrl = reg_wr && (sel == SEL_CTRL);
  assign wr_ahi  = reg_wr && (sel == SEL_AHI);
  assign wr_alo  = reg_wr && (sel == SEL_ALO);
  assign wr_dhi  = reg_wr && (sel == SEL_DHI);
  assign wr_dlo  = reg_wr && (sel == SEL_DLO);

  assign both_bits = reg_wdata[CTL_EXEC] && reg_wdata[CTL_WRITE];
  assign commit    = wr_ctrl && both_bits && !busy;
  assign crc_clr   = wr_ctrl && reg_wdata[CTL_CRCCLR] && !busy;
  assign ovf_set   = wr_ctrl && both_bits && busy;
  assign ovf_clr   = reg_rd && (sel == SEL_CTRL);

  // Next-state logic
  assign alo_nxt = reg_wdata & ALIGN_MASK;

  always_comb begin
    cnt_nxt = cnt_q;
    cnt_en  = 1'b0;
    if (wr_ahi) begin
      cnt_nxt = {reg_wdata, alo_q};
      cnt_en  = 1'b1;
    end else if (wr_alo) begin
      cnt_nxt = {ahi_q, alo_nxt};
      cnt_en  = 1'b1;
    end else if (commit) begin
      cnt_nxt = cnt_q + AW'(4);
      cnt_en  = 1'b1;
    end
  end

  always_comb begin
    ovf_nxt = ovf_q;
    ovf_en  = 1'b0;
    if (ovf_set) begin
      ovf_nxt = 1'b1;
      ovf_en  = 1'b1;
    end else if (ovf_clr) begin
      ovf_nxt = 1'b0;
      ovf_en  = 1'b1;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ahi_q <= '0;
      alo_q <= '0;
      dhi_q <= '0;
      dlo_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (wr_ahi) ahi_q <= reg_wdata;
      if (wr_alo) alo_q <= alo_nxt;
      if (wr_dhi) dhi_q <= reg_wdata;
      if (wr_dlo) dlo_q <= reg_wdata;
      if (cnt_en) cnt_q <= cnt_nxt;
      if (ovf_en) ovf_q <= ovf_nxt;
    end
  end

  // Read mux
  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_CTRL: begin
        reg_rdata[CTL_BUSY] = busy;
        reg_rdata[CTL_OVF]  = ovf_q;
      end
      SEL_CRC:  reg_rdata = crc_val;
      SEL_AHI:  reg_rdata = ahi_q;
      SEL_ALO:  reg_rdata = alo_q;
      SEL_DHI:  reg_rdata = dhi_q;
      SEL_DLO:  reg_rdata = dlo_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign word_addr = cnt_q;
  assign data_word = {dhi_q, dlo_q};
  assign ovf_flag  = ovf_q;

endmodule

// File: rtl/mbox_launch.sv
module mbox_launch #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [AW-1:0] word_addr,
  input  logic [DW-1:0] data_word,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data
);

  logic          vld_q, vld_nxt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_comb begin
    vld_nxt = vld_q;
    if (commit)
      vld_nxt = 1'b1;
    else if (vld_q && mem_ready)
      vld_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      vld_q <= vld_nxt;
      if (commit) begin
        addr_q <= word_addr;
        data_q <= data_word;
      end
    end
  end

  assign mem_valid = vld_q;
  assign mem_addr  = addr_q;
  assign mem_data  = data_q;

endmodule

// File: rtl/mbox_crc.sv
module mbox_crc #(
  parameter int             CW   = 16,
  parameter int             DW   = 32,
  parameter logic [CW-1:0]  POLY = 16'h1021
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          start,
  input  logic [DW-1:0] word,
  output logic [CW-1:0] crc,
  output logic          active
);

  localparam int CNT_W = $clog2(DW + 1);

  logic [CW-1:0]    crc_q, crc_nxt;
  logic [DW-1:0]    sh_q, sh_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             fb;
  logic             run;

  assign run = (cnt_q != '0);
  assign fb  = crc_q[CW-1] ^ sh_q[DW-1];

  always_comb begin
    crc_nxt = crc_q;
    sh_nxt  = sh_q;
    cnt_nxt = cnt_q;
    if (run) begin
      crc_nxt = {crc_q[CW-2:0], 1'b0} ^ (fb ? POLY : '0);
      sh_nxt  = {sh_q[DW-2:0], 1'b0};
      cnt_nxt = cnt_q - CNT_W'(1);
    end
    if (clr)
      crc_nxt = '0;
    if (start) begin
      sh_nxt  = word;
      cnt_nxt = CNT_W'(DW);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (run || clr)   crc_q <= crc_nxt;
      if (run || start) sh_q  <= sh_nxt;
      if (run || start) cnt_q <= cnt_nxt;
    end
  end

  assign crc    = crc_q;
  assign active = run;

endmodule

// File: rtl/wordload_mailbox.sv
module wordload_mailbox #(
  parameter int              REG_W = 16,
  parameter int              RA_W  = 16,
  parameter logic [RA_W-1:0] BASE  = 16'h0200,
  parameter logic [REG_W-1:0] POLY = 16'h1021
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [RA_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [2*REG_W-1:0] mem_addr,
  output logic [2*REG_W-1:0] mem_data
);

  localparam int AW = 2 * REG_W;
  localparam int DW = 2 * REG_W;

  logic          busy;
  logic          commit;
  logic          crc_clr;
  logic          crc_active;
  logic          ovf_flag;
  logic [REG_W-1:0] crc_val;
  logic [AW-1:0] word_addr;
  logic [DW-1:0] data_word;

  assign busy = mem_valid | crc_active;

  mbox_regs #(.REG_W(REG_W), .RA_W(RA_W), .BASE(BASE)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .crc_val   (crc_val),
    .commit    (commit),
    .crc_clr   (crc_clr),
    .word_addr (word_addr),
    .data_word (data_word),
    .ovf_flag  (ovf_flag)
  );

  mbox_launch #(.AW(AW), .DW(DW)) u_launch (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .word_addr (word_addr),
    .data_word (data_word),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data)
  );

  mbox_crc #(.CW(REG_W), .DW(DW), .POLY(POLY)) u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (crc_clr),
    .start  (commit),
    .word   (data_word),
    .crc    (crc_val),
    .active (crc_active)
  );

endmodule

// File: rtl/wordload_mailbox_chk.sv
module wordload_mailbox_chk #(
  parameter int              REG_W = 16,
  parameter int              RA_W  = 16,
  parameter logic [RA_W-1:0] BASE  = 16'h0200
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [RA_W-1:0]    reg_addr,
  input logic [REG_W-1:0]   reg_wdata,
  input logic               busy,
  input logic               ovf_flag,
  input logic [2*REG_W-1:0] data_word,
  input logic               mem_valid,
  input logic               mem_ready,
  input logic [2*REG_W-1:0] mem_addr,
  input logic [2*REG_W-1:0] mem_data
);

  logic ctl_wr, go_bits;
  assign ctl_wr  = reg_wr && (reg_addr == BASE);
  assign go_bits = reg_wdata[15] && reg_wdata[14];

  // R3
  commit_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && go_bits && !busy) |=> (mem_valid && mem_data == $past(data_word)));

  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && go_bits && busy) |=> ovf_flag);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  // R2
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[1:0] == 2'b00));

  // R4
  partial_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !go_bits && !mem_valid) |=> !mem_valid);

endmodule

bind wordload_mailbox wordload_mailbox_chk #(.REG_W(REG_W), .RA_W(RA_W), .BASE(BASE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .busy      (busy),
  .ovf_flag  (ovf_flag),
  .data_word (data_word),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data)
);

// File: tb/wordload_mailbox_test.sv
`timescale 1ns/100ps
module wordload_mailbox_test;

  localparam logic [15:0] A_CTL = 16'h0200, A_CRC = 16'h0201, A_AHI = 16'h0202,
                          A_ALO = 16'h0203, A_DHI = 16'h0204, A_DLO = 16'h0205;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_addr = 16'h0, reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        mem_valid, mem_ready = 1'b1;
  logic [31:0] mem_addr, mem_data;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wordload_mailbox uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] crc_word(logic [15:0] c, logic [31:0] w);
    for (int b = 3; b >= 0; b--) begin
      c = c ^ {w[b*8 +: 8], 8'h00};
      for (int k = 0; k < 8; k++)
        c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  // Behavioural reference model
  logic [15:0] m_ahi, m_alo, m_dhi, m_dlo, m_crc;
  logic [31:0] m_cnt, m_maddr, m_mdata;
  bit          m_valid, m_ovf;
  int          m_wait;

  function automatic bit m_busy();
    return m_valid || (m_wait > 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ahi = 0; m_alo = 0; m_dhi = 0; m_dlo = 0; m_crc = 0;
      m_cnt = 0; m_maddr = 0; m_mdata = 0; m_valid = 0; m_ovf = 0; m_wait = 0;
    end else begin
      bit b;
      b = m_busy();
      if (m_valid && mem_ready) m_valid = 0;
      if (m_wait > 0) m_wait--;
      if (reg_rd && reg_addr == A_CTL) m_ovf = 0;
      if (reg_wr) begin
        case (reg_addr)
          A_AHI: begin m_ahi = reg_wdata; m_cnt = {m_ahi, m_alo}; end
          A_ALO: begin m_alo = reg_wdata & 16'hFFFC; m_cnt = {m_ahi, m_alo}; end
          A_DHI: m_dhi = reg_wdata;
          A_DLO: m_dlo = reg_wdata;
          A_CTL: begin
            if (!b) begin
              if (reg_wdata[12]) m_crc = 0;
              if (reg_wdata[15] && reg_wdata[14]) begin
                m_valid = 1; m_maddr = m_cnt; m_mdata = {m_dhi, m_dlo};
                m_crc = crc_word(m_crc, {m_dhi, m_dlo});
                m_wait = 32; m_cnt = m_cnt + 4;
              end
            end else if (reg_wdata[15] && reg_wdata[14]) m_ovf = 1;
          end
          default: ;
        endcase
      end
    end
  end

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10 mem_valid", {31'b0, mem_valid}, {31'b0, m_valid});
      if (m_valid) begin
        chk("R5 mem_addr", mem_addr, m_maddr);
        chk("R3 mem_data", mem_data, m_mdata);
      end
      case (reg_addr)
        A_CTL: chk("R8 ctrl", {16'h0, reg_rdata}, {16'h0, 7'b0, m_busy(), 7'b0, m_ovf});
        A_CRC: if (!m_busy()) chk("R6 crc", {16'h0, reg_rdata}, {16'h0, m_crc});
        A_AHI: chk("R5 ahi", {16'h0, reg_rdata}, {16'h0, m_ahi});
        A_ALO: chk("R2 alo", {16'h0, reg_rdata}, {16'h0, m_alo});
        A_DHI: chk("R3 dhi", {16'h0, reg_rdata}, {16'h0, m_dhi});
        A_DLO: chk("R3 dlo", {16'h0, reg_rdata}, {16'h0, m_dlo});
        default: ;
      endcase
    end
  end

  task automatic wr(logic [15:0] a, logic [15:0] d);
    @(negedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [15:0] v);
    @(negedge clk); #1;
    reg_rd = 1; reg_addr = a;
    #0.5 v = reg_rdata;
    @(negedge clk); #1;
    reg_rd = 0;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 300; i++) begin
      rd(A_CTL, v);
      if (!v[8]) return;
    end
    chk("R8 busy never dropped", 1, 0);
  endtask

  task automatic load(logic [31:0] w);
    wr(A_DHI, w[31:16]);
    wr(A_DLO, w[15:0]);
    wr(A_CTL, 16'hC000);
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] ref_crc;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd(A_CTL, v); chk("R1 ctrl", {16'h0, v}, 32'h0);
    rd(A_CRC, v); chk("R1 crc", {16'h0, v}, 32'h0);
    rd(A_ALO, v); chk("R1 alo", {16'h0, v}, 32'h0);
    chk("R1 mem_valid", {31'b0, mem_valid}, 32'h0);

    // R2 alignment
    wr(A_AHI, 16'h1234);
    wr(A_ALO, 16'h5677);
    rd(A_ALO, v); chk("R2 low bits dropped", {16'h0, v}, 32'h5674);

    // R3 / R5 / R6 contiguous load with ready high
    ref_crc = 0;
    load(32'h31323334);
    chk("R3 valid after commit", {31'b0, mem_valid}, 32'h1);
    chk("R3 addr after commit", mem_addr, 32'h12345674);
    chk("R3 data after commit", mem_data, 32'h31323334);
    ref_crc = crc_word(ref_crc, 32'h31323334);
    wait_idle();
    load(32'hDEADBEEF);
    chk("R5 address advanced", mem_addr, 32'h12345678);
    ref_crc = crc_word(ref_crc, 32'hDEADBEEF);
    wait_idle();
    rd(A_CRC, v); chk("R6 crc two words", {16'h0, v}, {16'h0, ref_crc});

    // R4 partial control writes
    wr(A_DLO, 16'h0001);
    wr(A_CTL, 16'h8000);
    chk("R4 execute only", {31'b0, mem_valid}, 32'h0);
    wr(A_CTL, 16'h4000);
    chk("R4 write only", {31'b0, mem_valid}, 32'h0);
    rd(A_CRC, v); chk("R4 crc unchanged", {16'h0, v}, {16'h0, ref_crc});

    // R7 clear with commit in same write
    wr(A_DHI, 16'hA55A);
    wr(A_DLO, 16'h0F0F);
    wr(A_CTL, 16'hD000);
    chk("R5 third address", mem_addr, 32'h1234567C);
    wait_idle();
    rd(A_CRC, v); chk("R7 clear plus commit", {16'h0, v}, {16'h0, crc_word(16'h0, 32'hA55A0F0F)});
    wr(A_CTL, 16'h1000);
    rd(A_CRC, v); chk("R7 clear alone", {16'h0, v}, 32'h0);

    // R8 / R9 / R10 stalled memory port
    @(negedge clk); #1 mem_ready = 0;
    wr(A_ALO, 16'h0100);
    load(32'h11112222);
    wr(A_DLO, 16'h3333);
    wr(A_CTL, 16'hC000);
    wr(A_CTL, 16'h1000);
    repeat (40) @(negedge clk);
    #0.5;
    chk("R10 held valid", {31'b0, mem_valid}, 32'h1);
    chk("R10 held data", mem_data, 32'h11112222);
    chk("R10 held addr", mem_addr, 32'h12340100);
    rd(A_CTL, v);
    chk("R8 busy while stalled", {31'b0, v[8]}, 32'h1);
    chk("R9 overflow set", {31'b0, v[0]}, 32'h1);
    rd(A_CTL, v);
    chk("R9 overflow cleared", {31'b0, v[0]}, 32'h0);
    @(negedge clk); #1 mem_ready = 1;
    wait_idle();
    rd(A_CRC, v); chk("R9 crc reset ignored while busy", {16'h0, v}, {16'h0, crc_word(16'h0, 32'h11112222)});

    // R5 reload after increments
    wr(A_AHI, 16'h0040);
    load(32'h00000001);
    chk("R5 reload address", mem_addr, 32'h00400100);
    wait_idle();

    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule